// File: doc/BRIEF.md
# Even/Odd Polyphase Filter Branch with Shared Multipliers

This block is a single branch of a polyphase bank that converts a complex sub-band into baseband channels. It takes the stream of complex samples that reaches this branch (one sample in every M of the full-rate stream), runs it through a delay line of TAPS complex samples, and multiplies each stored sample by a complex coefficient. It produces two complex results for every accepted input sample. One result feeds the even group of output channels and the other feeds the odd group.

The two filters of a branch use the same coefficients, except that the odd filter's coefficients at odd tap positions have the opposite sign. The block therefore computes a single bank of products. It forms one partial sum A over the even-indexed taps and one partial sum B over the odd-indexed taps. The even result is A+B and the odd result is A−B. Both are rounded and saturated to OW bits per component.

Coefficients are written one tap at a time through an address/data port. A write is accepted only while no sample is entering or moving through the pipeline. A valid flag travels with each sample, and the result appears a fixed number of cycles after the input.

Top module: `pbr_branch`

## Requirements
- R1: After reset, out_valid and busy are 0, all four result outputs are 0, and every coefficient is 0, so any sample filtered before a coefficient load gives zero results.
- R2: Each cycle with in_valid high produces exactly one cycle with out_valid high, three clock edges after the edge that sampled in_valid. No other cycle has out_valid high.
- R3: The even result is rnd(A+B). Tap r (coefficient address r, r = 0..TAPS−1) multiplies the sample accepted r samples before the newest one. A is the sum of the products at even r, and B is the sum of the products at odd r.
- R4: The odd result is rnd(A−B), which is the same filter with the coefficients at odd tap addresses negated.
- R5: Each tap product is a full complex product at full precision: real part xr·cr − xi·ci, imaginary part xr·ci + xi·cr.
- R6: The delay line advances only on cycles with in_valid high. Idle cycles between samples do not change the tap contents.
- R7: A write (cfg_we high while busy is low) stores cfg_re/cfg_im at tap cfg_addr from the next cycle on.
- R8: busy is high whenever in_valid is high or a sample is in the first three pipeline stages. A write presented while busy is high is ignored and leaves every coefficient unchanged.
- R9: Rounding adds 2^(RSH−1) and then shifts right arithmetically by RSH (round half up). With RSH = 9 and a single unit coefficient, inputs 256, 255, −256 and −257 give 1, 0, 0 and −1.
- R10: A rounded value outside the signed OW-bit range is clamped to 2^(OW−1)−1 or −2^(OW−1).
- R11: The four result outputs keep their values on every cycle that does not complete a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Branch input sample present |
| in_re | input | DW | Input sample, real part (signed) |
| in_im | input | DW | Input sample, imaginary part (signed) |
| cfg_we | input | 1 | Coefficient write request |
| cfg_addr | input | $clog2(TAPS) | Tap index to write |
| cfg_re | input | CW | Coefficient real part (signed) |
| cfg_im | input | CW | Coefficient imaginary part (signed) |
| busy | output | 1 | Pipeline occupied; writes are refused |
| out_valid | output | 1 | Results valid this cycle |
| even_re | output | OW | Even-group result, real part |
| even_im | output | OW | Even-group result, imaginary part |
| odd_re | output | OW | Odd-group result, real part |
| odd_im | output | OW | Odd-group result, imaginary part |

## Verification
The assertions check, on every cycle, the timing and control behaviour. They confirm that each valid flag steps through the stages one edge at a time with none created spuriously, that an accepted write lands at its address, that a refused write leaves the coefficient store unchanged, and that the results hold between completions. The arithmetic can only be shown by the bench's scenarios, which compare results against an independent model. These scenarios cover impulse responses that expose each tap with its sign flip, a mixed complex stream, gapped input, rounding ties and saturation at both rails.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

  // Round half up by an arithmetic right shift, then clamp to a signed width.
  function automatic longint rnd_sat(input longint v, input int sh, input int ow);
    longint t;
    longint hi;
    longint lo;
    t = v;
    if (sh > 0) t = (v + (longint'(1) <<< (sh - 1))) >>> sh;
    hi = (longint'(1) <<< (ow - 1)) - 1;
    lo = -hi - 1;
    if (t > hi) t = hi;
    else if (t < lo) t = lo;
    return t;
  endfunction

endpackage

// File: rtl/pbr_coef_bank.sv
module pbr_coef_bank #(
  parameter int TAPS = 16,
  parameter int CW   = 10,
  parameter int AW   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic signed [CW-1:0] wr_re,
  input  logic signed [CW-1:0] wr_im,
  output logic signed [CW-1:0] c_re [TAPS],
  output logic signed [CW-1:0] c_im [TAPS]
);

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        c_re[t] <= '0;
        c_im[t] <= '0;
      end else if (wr_en && (wr_addr == AW'(t))) begin
        c_re[t] <= wr_re;
        c_im[t] <= wr_im;
      end
    end
  end

endmodule

// File: rtl/pbr_delay_line.sv
module pbr_delay_line #(
  parameter int TAPS = 16,
  parameter int DW   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic signed [DW-1:0] x_re [TAPS],
  output logic signed [DW-1:0] x_im [TAPS]
);

  for (genvar t = 0; t < TAPS; t++) begin : g_stage
    if (t == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          x_re[0] <= '0;
          x_im[0] <= '0;
        end else if (shift) begin
          x_re[0] <= in_re;
          x_im[0] <= in_im;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          x_re[t] <= '0;
          x_im[t] <= '0;
        end else if (shift) begin
          x_re[t] <= x_re[t-1];
          x_im[t] <= x_im[t-1];
        end
      end
    end
  end

endmodule

// File: rtl/pbr_mac.sv
module pbr_mac #(
  parameter int TAPS = 16,
  parameter int DW   = 16,
  parameter int CW   = 10,
  parameter int PW   = 27,
  parameter int SW   = 30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_in,
  input  logic signed [DW-1:0] x_re [TAPS],
  input  logic signed [DW-1:0] x_im [TAPS],
  input  logic signed [CW-1:0] c_re [TAPS],
  input  logic signed [CW-1:0] c_im [TAPS],
  output logic                 v_mid,
  output logic                 v_out,
  output logic signed [SW-1:0] a_re,
  output logic signed [SW-1:0] a_im,
  output logic signed [SW-1:0] b_re,
  output logic signed [SW-1:0] b_im
);

  function automatic logic signed [PW-1:0] smul(input logic signed [DW-1:0] x,
                                                input logic signed [CW-1:0] c);
    return PW'(x) * PW'(c);
  endfunction

  logic signed [PW-1:0] p_re [TAPS];
  logic signed [PW-1:0] p_im [TAPS];

  for (genvar t = 0; t < TAPS; t++) begin : g_prod
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        p_re[t] <= '0;
        p_im[t] <= '0;
      end else if (v_in) begin
        p_re[t] <= smul(x_re[t], c_re[t]) - smul(x_im[t], c_im[t]);
        p_im[t] <= smul(x_re[t], c_im[t]) + smul(x_im[t], c_re[t]);
      end
    end
  end

  logic signed [SW-1:0] sa_re, sa_im, sb_re, sb_im;

  always_comb begin
    sa_re = '0;
    sa_im = '0;
    sb_re = '0;
    sb_im = '0;
    for (int t = 0; t < TAPS; t++) begin
      if ((t % 2) == 0) begin
        sa_re = sa_re + SW'(p_re[t]);
        sa_im = sa_im + SW'(p_im[t]);
      end else begin
        sb_re = sb_re + SW'(p_re[t]);
        sb_im = sb_im + SW'(p_im[t]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_mid <= 1'b0;
      v_out <= 1'b0;
      a_re  <= '0;
      a_im  <= '0;
      b_re  <= '0;
      b_im  <= '0;
    end else begin
      v_mid <= v_in;
      v_out <= v_mid;
      if (v_mid) begin
        a_re <= sa_re;
        a_im <= sa_im;
        b_re <= sb_re;
        b_im <= sb_im;
      end
    end
  end

endmodule

// File: rtl/pbr_combine.sv
module pbr_combine #(
  parameter int SW  = 30,
  parameter int OW  = 16,
  parameter int RSH = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_in,
  input  logic signed [SW-1:0] a_re,
  input  logic signed [SW-1:0] a_im,
  input  logic signed [SW-1:0] b_re,
  input  logic signed [SW-1:0] b_im,
  output logic                 v_out,
  output logic signed [OW-1:0] even_re,
  output logic signed [OW-1:0] even_im,
  output logic signed [OW-1:0] odd_re,
  output logic signed [OW-1:0] odd_im
);

  import pbr_pkg::*;

  function automatic logic signed [OW-1:0] fold(input longint v);
    return OW'(rnd_sat(v, RSH, OW));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_out   <= 1'b0;
      even_re <= '0;
      even_im <= '0;
      odd_re  <= '0;
      odd_im  <= '0;
    end else begin
      v_out <= v_in;
      if (v_in) begin
        even_re <= fold(longint'(a_re) + longint'(b_re));
        even_im <= fold(longint'(a_im) + longint'(b_im));
        odd_re  <= fold(longint'(a_re) - longint'(b_re));
        odd_im  <= fold(longint'(a_im) - longint'(b_im));
      end
    end
  end

endmodule

// File: rtl/pbr_branch.sv
module pbr_branch #(
  parameter int TAPS = 16,
  parameter int DW   = 16,
  parameter int CW   = 10,
  parameter int OW   = 16,
  parameter int RSH  = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic signed [DW-1:0]        in_re,
  input  logic signed [DW-1:0]        in_im,
  input  logic                        cfg_we,
  input  logic [$clog2(TAPS)-1:0]     cfg_addr,
  input  logic signed [CW-1:0]        cfg_re,
  input  logic signed [CW-1:0]        cfg_im,
  output logic                        busy,
  output logic                        out_valid,
  output logic signed [OW-1:0]        even_re,
  output logic signed [OW-1:0]        even_im,
  output logic signed [OW-1:0]        odd_re,
  output logic signed [OW-1:0]        odd_im
);

  localparam int AW = $clog2(TAPS);
  localparam int PW = DW + CW + 1;
  localparam int SW = PW + $clog2(TAPS / 2) + 1;

  logic signed [DW-1:0] x_re [TAPS];
  logic signed [DW-1:0] x_im [TAPS];
  logic signed [CW-1:0] c_re [TAPS];
  logic signed [CW-1:0] c_im [TAPS];
  logic signed [SW-1:0] a_re, a_im, b_re, b_im;

  logic v_line, v_prod, v_sum;
  logic cfg_take;
  logic [TAPS*2*CW-1:0] coef_flat;

  assign busy     = in_valid | v_line | v_prod | v_sum;
  assign cfg_take = cfg_we & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) v_line <= 1'b0;
    else        v_line <= in_valid;
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_flat
    assign coef_flat[t*2*CW +: 2*CW] = {c_re[t], c_im[t]};
  end

  pbr_coef_bank #(.TAPS(TAPS), .CW(CW), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_take), .wr_addr(cfg_addr),
    .wr_re(cfg_re), .wr_im(cfg_im), .c_re(c_re), .c_im(c_im)
  );

  pbr_delay_line #(.TAPS(TAPS), .DW(DW)) u_line (
    .clk(clk), .rst_n(rst_n), .shift(in_valid), .in_re(in_re), .in_im(in_im),
    .x_re(x_re), .x_im(x_im)
  );

  pbr_mac #(.TAPS(TAPS), .DW(DW), .CW(CW), .PW(PW), .SW(SW)) u_mac (
    .clk(clk), .rst_n(rst_n), .v_in(v_line),
    .x_re(x_re), .x_im(x_im), .c_re(c_re), .c_im(c_im),
    .v_mid(v_prod), .v_out(v_sum),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im)
  );

  pbr_combine #(.SW(SW), .OW(OW), .RSH(RSH)) u_comb (
    .clk(clk), .rst_n(rst_n), .v_in(v_sum),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .v_out(out_valid), .even_re(even_re), .even_im(even_im),
    .odd_re(odd_re), .odd_im(odd_im)
  );

endmodule

// File: rtl/pbr_chk.sv
module pbr_chk #(
  parameter int TAPS = 16,
  parameter int CW   = 10,
  parameter int AW   = 4,
  parameter int OW   = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 busy,
  input logic                 cfg_we,
  input logic [AW-1:0]        cfg_addr,
  input logic [CW-1:0]        cfg_re,
  input logic [CW-1:0]        cfg_im,
  input logic                 v_line,
  input logic                 v_prod,
  input logic                 v_sum,
  input logic                 out_valid,
  input logic [OW-1:0]        even_re,
  input logic [OW-1:0]        even_im,
  input logic [OW-1:0]        odd_re,
  input logic [OW-1:0]        odd_im,
  input logic [TAPS*2*CW-1:0] coef_flat
);

  AST_STAGE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> v_line);  // R2
  AST_STAGE_PROD: assert property (@(posedge clk) disable iff (!rst_n)
    v_line |=> v_prod);  // R2
  AST_STAGE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    v_prod |=> v_sum);  // R2
  AST_STAGE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    v_sum |=> out_valid);  // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(v_sum));  // R2
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !v_sum |=> $stable({even_re, even_im, odd_re, odd_im}));  // R11
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !busy && (int'(cfg_addr) < TAPS)) |=>
      (coef_flat[$past(cfg_addr)*2*CW +: 2*CW] == $past({cfg_re, cfg_im})));  // R7
  AST_WRITE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && busy) |=> $stable(coef_flat));  // R8

endmodule

bind pbr_branch pbr_chk #(.TAPS(TAPS), .CW(CW), .AW(AW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .busy(busy),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_re(cfg_re), .cfg_im(cfg_im),
  .v_line(v_line), .v_prod(v_prod), .v_sum(v_sum), .out_valid(out_valid),
  .even_re(even_re), .even_im(even_im), .odd_re(odd_re), .odd_im(odd_im),
  .coef_flat(coef_flat)
);

// File: tb/tb_pbr_branch.sv
module tb_pbr_branch;

  localparam int TAPS = 16;
  localparam int DW   = 16;
  localparam int CW   = 10;
  localparam int OW   = 16;
  localparam int RSH  = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_re = '0, in_im = '0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic signed [CW-1:0] cfg_re = '0, cfg_im = '0;
  logic busy, out_valid;
  logic signed [OW-1:0] even_re, even_im, odd_re, odd_im;

  always #10 clk = ~clk;

  pbr_branch #(.TAPS(TAPS), .DW(DW), .CW(CW), .OW(OW), .RSH(RSH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_re(cfg_re), .cfg_im(cfg_im),
    .busy(busy), .out_valid(out_valid), .even_re(even_re), .even_im(even_im),
    .odd_re(odd_re), .odd_im(odd_im)
  );

  int n_chk = 0;
  int n_bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // independent model state
  longint mc_re [TAPS];
  longint mc_im [TAPS];
  longint h_re  [TAPS];
  longint h_im  [TAPS];
  longint q_er[$], q_ei[$], q_or[$], q_oi[$], q_t[$];
  string  q_tag[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic longint clampr(input longint v);
    longint r, top;
    r = (v + (longint'(1) <<< (RSH - 1))) >>> RSH;  // R9 round half up
    top = (longint'(1) <<< (OW - 1)) - 1;
    if (r > top) r = top;                           // R10 clamp high
    if (r < -top - 1) r = -top - 1;                 // R10 clamp low
    return r;
  endfunction

  task automatic model_push(input longint xr, input longint xi, input string tag);
    longint ar, ai, br, bi, pr, pi;
    for (int t = TAPS - 1; t > 0; t--) begin
      h_re[t] = h_re[t-1];
      h_im[t] = h_im[t-1];
    end
    h_re[0] = xr;
    h_im[0] = xi;
    ar = 0; ai = 0; br = 0; bi = 0;
    for (int t = 0; t < TAPS; t++) begin
      pr = h_re[t] * mc_re[t] - h_im[t] * mc_im[t];  // R5
      pi = h_re[t] * mc_im[t] + h_im[t] * mc_re[t];
      if (t % 2 == 0) begin ar += pr; ai += pi; end
      else            begin br += pr; bi += pi; end
    end
    q_er.push_back(clampr(ar + br));  // R3
    q_ei.push_back(clampr(ai + bi));
    q_or.push_back(clampr(ar - br));  // R4
    q_oi.push_back(clampr(ai - bi));
    q_t.push_back(cyc);
    q_tag.push_back(tag);
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_er.size() == 0) begin
        check(1'b0, "R2", "unexpected out_valid", 1, 0);
      end else begin
        string tg;
        longint t0;
        tg = q_tag.pop_front();
        t0 = q_t.pop_front();
        check(cyc - t0 == 4, "R2", "latency", cyc - t0, 4);
        begin
          longint e;
          e = q_er.pop_front(); check(even_re == e, tg, "even_re", even_re, e);
          e = q_ei.pop_front(); check(even_im == e, tg, "even_im", even_im, e);
          e = q_or.pop_front(); check(odd_re == e, tg, "odd_re", odd_re, e);
          e = q_oi.pop_front(); check(odd_im == e, tg, "odd_im", odd_im, e);
        end
      end
    end
  end

  task automatic send(input longint xr, input longint xi, input string tag);
    @(negedge clk);
    model_push(xr, xi, tag);
    in_valid = 1'b1;
    in_re = DW'(xr);
    in_im = DW'(xi);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wcfg(input int a, input longint cr, input longint ci);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we = 1'b1;
    cfg_addr = 4'(a);
    cfg_re = CW'(cr);
    cfg_im = CW'(ci);
    mc_re[a] = cr;  // bench only writes this way while the pipe is idle
    mc_im[a] = ci;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic flush_history(input string tag);
    for (int i = 0; i < TAPS; i++) send(0, 0, tag);
    idle(6);
  endtask

  task automatic t_reset;
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    check(busy == 0, "R1", "busy after reset", busy, 0);
    check(even_re == 0 && even_im == 0 && odd_re == 0 && odd_im == 0,
          "R1", "results after reset", even_re, 0);
    send(1000, -700, "R1");
    send(-32768, 32767, "R1");
    idle(6);
  endtask

  task automatic t_impulse;
    for (int t = 0; t < TAPS; t++) wcfg(t, t * 37 - 200, 100 - t * 13);  // R7
    send(longint'(1) <<< RSH, 0, "R3");
    for (int t = 1; t < TAPS; t++) send(0, 0, "R4");
    send(0, longint'(1) <<< RSH, "R4");
    for (int t = 1; t < TAPS; t++) send(0, 0, "R3");
    idle(6);
  endtask

  task automatic t_mixed;
    for (int i = 0; i < 40; i++)
      send(((i * 7919) % 20000) - 10000, ((i * 104729) % 16000) - 8000, "R5");
    idle(6);
  endtask

  task automatic t_gaps;
    for (int i = 0; i < 10; i++) begin
      send(3000 - i * 611, i * 257 - 1200, "R6");
      idle(i % 4);
    end
    idle(6);
  endtask

  task automatic t_busy_write;
    wcfg(0, 100, -50);
    flush_history("R8");
    send(4000, 0, "R8");
    @(negedge clk);
    in_valid = 1'b0;
    check(busy == 1, "R8", "busy one cycle after input", busy, 1);
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_re = -10'sd300; cfg_im = 10'sd77;
    @(negedge clk);
    cfg_we = 1'b0;
    // write alongside an input sample is refused too
    model_push(512, 0, "R8");
    in_valid = 1'b1; in_re = 16'sd512; in_im = '0;
    cfg_we = 1'b1; cfg_addr = 4'd1; cfg_re = 10'sd211; cfg_im = 10'sd0;
    idle(6);
    send(1 <<< RSH, 0, "R8");
    idle(6);
  endtask

  task automatic t_round;
    for (int t = 0; t < TAPS; t++) wcfg(t, 0, 0);
    wcfg(0, 1, 0);
    send(256, 255, "R9");
    idle(5);
    check(even_re == 1 && even_im == 0, "R9", "ties at +256/255", even_re, 1);
    send(-256, -257, "R9");
    idle(5);
    check(even_re == 0 && even_im == -1, "R9", "ties at -256/-257", even_im, -1);
  endtask

  task automatic t_sat;
    for (int t = 0; t < TAPS; t++) wcfg(t, 511, 0);
    for (int i = 0; i < TAPS; i++) send(32767, 0, "R10");
    idle(5);
    check(even_re == 32767, "R10", "positive rail", even_re, 32767);
    for (int i = 0; i < TAPS; i++) send(-32768, 0, "R10");
    idle(5);
    check(even_re == -32768, "R10", "negative rail", even_re, -32768);
  endtask

  task automatic t_hold;
    logic signed [OW-1:0] s0, s1, s2, s3;
    s0 = even_re; s1 = even_im; s2 = odd_re; s3 = odd_im;
    wcfg(3, -5, 9);
    idle(5);
    check(out_valid == 0, "R11", "no result while idle", out_valid, 0);
    check(even_re == s0 && even_im == s1 && odd_re == s2 && odd_im == s3,
          "R11", "results held", even_re, s0);
  endtask

  bit done = 0;

  initial begin
    for (int t = 0; t < TAPS; t++) begin
      mc_re[t] = 0; mc_im[t] = 0; h_re[t] = 0; h_im[t] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_impulse;
    t_mixed;
    t_gaps;
    t_busy_write;
    t_round;
    t_sat;
    t_hold;
    check(q_er.size() == 0, "R2", "results still owed", q_er.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule